// File: doc/BRIEF.md
# Parallel Configuration Target Sequencer

This block is the receiving end of a byte-wide passive configuration link. After a power-up reset it runs its own power-on delay, and the delay is short or long depending on a select input. Through that delay it holds an open-drain status line low and keeps the user-side outputs disabled. A host then raises a configuration request. Once the status line is released and reads high, the host places one byte per rising edge of a configuration clock on an 8-bit bus. The block captures those bytes, counts them, and moves through three stages: reset, configuration and initialization. It then enters user mode and signals done.

In compressed or secured transfers, only one rising configuration clock edge in four carries a byte. The next three edges are spent processing it. The status line is modelled as a wired-AND of the block's own pull-down enable and an external level, so an outside agent can hold the block in reset or push it back into reset. The configuration clock is an ordinary input that is oversampled by the system clock.

Top module: `cfg_target_seq`

## Requirements
- R1: While the power-on delay runs (`por_busy`=1), `stage` reads 0, `stat_drive_low`=1, `stat_line`=0, `user_oe`=0, `done`=0 and `byte_count`=0.
- R2: With `por_short_sel` held stable, `por_busy` is still 1 after N rising `clk` edges following the release of `rst_n`, and is 0 after N+1 edges. N is POR_LONG_CYC when the select is 0 and POR_SHORT_CYC when it is 1.
- R3: `stat_drive_low` is 1 during the power-on delay and whenever `cfg_req` is 0. `stat_line` equals `stat_ext` AND NOT `stat_drive_low`.
- R4: While `stat_line` is 0 the block stays in, or returns within one edge to, the reset stage (`stage`=0). A low `stat_ext` in user mode clears `done` and `user_oe`.
- R5: In the reset stage, with `cfg_req`=1 and `stat_line`=1 at a rising `clk` edge, `stage` becomes 1 (configuration) at that edge.
- R6: `cfg_req`=0 at any rising `clk` edge puts `stage` at 0 at that edge, and `byte_count` reads 0 by the following edge.
- R7: In the configuration stage with `comp_mode`=0, each rising edge of `cfg_clk` (each level held at least two `clk` cycles) captures `cfg_data`. One cycle later `cap_valid` pulses with that byte on `cap_data`, and `byte_count` has grown by one.
- R8: With `comp_mode`=1, only the 1st, 5th, 9th, ... rising `cfg_clk` edges of the configuration stage capture a byte. The three rises after each capture are processing edges, and the stage does not end until the last of them has occurred.
- R9: After TOTAL_BYTES captures (plus the three processing rises in compressed mode), `stage` is 2 for exactly INIT_CYC cycles, then 3 with `done`=1 and `user_oe`=1. No further `cfg_clk` rise is captured.
- R10: Stages are entered only in the order 0, 1, 2, 3. Stage 2 is reached only from stage 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| por_short_sel | input | 1 | 1 selects the short power-on delay |
| cfg_req | input | 1 | Configuration request from the host; low aborts |
| stat_ext | input | 1 | External level of the status net (1 = pull-up only) |
| stat_line | output | 1 | Resolved status net (wired-AND) |
| stat_drive_low | output | 1 | Block pulls the status net low |
| comp_mode | input | 1 | One byte per four configuration clock rises |
| cfg_clk | input | 1 | Configuration clock, oversampled |
| cfg_data | input | 8 | Configuration byte bus |
| cap_valid | output | 1 | One-cycle pulse per captured byte |
| cap_data | output | 8 | Last captured byte |
| byte_count | output | $clog2(TOTAL_BYTES+1) | Bytes captured in this attempt |
| stage | output | 2 | 0 reset, 1 configuration, 2 initialization, 3 user |
| por_busy | output | 1 | Power-on delay running |
| done | output | 1 | Configuration and initialization complete |
| user_oe | output | 1 | User outputs enabled (0 = tri-state) |

## Verification
The bench builds the block with POR_LONG_CYC=40, POR_SHORT_CYC=5, TOTAL_BYTES=6 and INIT_CYC=4. These values keep both power-on delays short enough to measure edge by edge. They also let one run hold many complete configuration attempts in both transfer modes, with random bytes. Using only six bytes per attempt makes the end of the stage, the compressed-mode processing tail, aborts midway and external status faults in user mode all come up many times.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_RST  = 3'd1,
    ST_CFG  = 3'd2,
    ST_INIT = 3'd3,
    ST_USER = 3'd4
  } seq_st_e;

  localparam logic [1:0] STG_RESET = 2'd0;
  localparam logic [1:0] STG_CFG   = 2'd1;
  localparam logic [1:0] STG_INIT  = 2'd2;
  localparam logic [1:0] STG_USER  = 2'd3;

  // Power-on delay length picked by the select input.
  function automatic int unsigned por_limit(input logic short_sel,
                                            input int unsigned long_c,
                                            input int unsigned short_c);
    return short_sel ? short_c : long_c;
  endfunction

  // Position inside the four-rise group of compressed mode.
  function automatic logic [1:0] phase_step(input logic [1:0] ph);
    return ph + 2'd1;
  endfunction

  // Whether a rise at the given phase carries a byte.
  function automatic logic rise_carries_byte(input logic comp, input logic [1:0] ph);
    return !comp || (ph == 2'd0);
  endfunction

  function automatic logic [1:0] stage_code(input seq_st_e s);
    case (s)
      ST_CFG:  return STG_CFG;
      ST_INIT: return STG_INIT;
      ST_USER: return STG_USER;
      default: return STG_RESET;
    endcase
  endfunction

endpackage

// File: rtl/cfgseq_por.sv
module cfgseq_por #(
  parameter int unsigned LONG_CYC  = 100,
  parameter int unsigned SHORT_CYC = 12,
  localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
  localparam int unsigned W    = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_sel,
  output logic por_done
);
  import cfgseq_pkg::*;

  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  assign limit    = W'(por_limit(short_sel, LONG_CYC, SHORT_CYC));
  assign por_done = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!por_done) begin
      cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/cfgseq_capture.sv
module cfgseq_capture #(
  parameter int unsigned TOTAL_BYTES = 16,
  localparam int unsigned CW = $clog2(TOTAL_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          active,
  input  logic          comp,
  input  logic          cfg_clk,
  input  logic [7:0]    cfg_data,
  output logic [CW-1:0] count,
  output logic          cap_valid,
  output logic [7:0]    cap_data,
  output logic          complete
);
  import cfgseq_pkg::*;

  logic       clk_q;
  logic [1:0] ph;
  logic       cfg_rise;
  logic       full;
  logic       take;
  logic       ph_adv;

  assign cfg_rise = cfg_clk & ~clk_q;
  assign full     = (count == CW'(TOTAL_BYTES));
  assign take     = active & cfg_rise & ~full & rise_carries_byte(comp, ph);
  assign ph_adv   = active & cfg_rise & comp & ((ph != 2'd0) | take);
  assign complete = full & (!comp || (ph == 2'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q     <= 1'b0;
      cap_valid <= 1'b0;
      cap_data  <= '0;
      count     <= '0;
      ph        <= '0;
    end else begin
      clk_q     <= cfg_clk;
      cap_valid <= take;
      if (take) cap_data <= cfg_data;
      if (clear) begin
        count <= '0;
        ph    <= '0;
      end else begin
        if (take)   count <= count + CW'(1);
        if (ph_adv) ph    <= phase_step(ph);
      end
    end
  end

endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl #(
  parameter int unsigned INIT_CYC = 8,
  localparam int unsigned IW = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_done,
  input  logic                 cfg_req,
  input  logic                 stat_line,
  input  logic                 complete,
  output cfgseq_pkg::seq_st_e  state,
  output logic                 drive_low
);
  import cfgseq_pkg::*;

  seq_st_e       nxt;
  logic [IW-1:0] icnt;
  logic          init_last;

  assign init_last = (state == ST_INIT) && (icnt == IW'(INIT_CYC - 1));
  assign drive_low = (state == ST_POR) | ~cfg_req;

  always_comb begin
    nxt = state;
    if (state == ST_POR) begin
      if (por_done) nxt = ST_RST;
    end else if (!cfg_req || !stat_line) begin
      nxt = ST_RST;
    end else begin
      case (state)
        ST_RST:  nxt = ST_CFG;
        ST_CFG:  if (complete)  nxt = ST_INIT;
        ST_INIT: if (init_last) nxt = ST_USER;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_POR;
      icnt  <= '0;
    end else begin
      state <= nxt;
      if (state == ST_INIT) icnt <= icnt + IW'(1);
      else                  icnt <= '0;
    end
  end

endmodule

// File: rtl/cfg_target_seq.sv
module cfg_target_seq #(
  parameter int unsigned POR_LONG_CYC  = 100,
  parameter int unsigned POR_SHORT_CYC = 12,
  parameter int unsigned TOTAL_BYTES   = 16,
  parameter int unsigned INIT_CYC      = 8,
  localparam int unsigned CW = $clog2(TOTAL_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_short_sel,
  input  logic          cfg_req,
  input  logic          stat_ext,
  output logic          stat_line,
  output logic          stat_drive_low,
  input  logic          comp_mode,
  input  logic          cfg_clk,
  input  logic [7:0]    cfg_data,
  output logic          cap_valid,
  output logic [7:0]    cap_data,
  output logic [CW-1:0] byte_count,
  output logic [1:0]    stage,
  output logic          por_busy,
  output logic          done,
  output logic          user_oe
);
  import cfgseq_pkg::*;

  seq_st_e state;
  logic    por_done;
  logic    complete;
  logic    cap_active;
  logic    cap_clear;

  assign stat_line  = stat_ext & ~stat_drive_low;
  assign cap_active = (state == ST_CFG) & cfg_req & stat_line;
  assign cap_clear  = (state == ST_POR) | (state == ST_RST);
  assign stage      = stage_code(state);
  assign por_busy   = (state == ST_POR);
  assign done       = (state == ST_USER);
  assign user_oe    = (state == ST_USER);

  cfgseq_por #(
    .LONG_CYC (POR_LONG_CYC),
    .SHORT_CYC(POR_SHORT_CYC)
  ) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .short_sel(por_short_sel),
    .por_done (por_done)
  );

  cfgseq_capture #(
    .TOTAL_BYTES(TOTAL_BYTES)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cap_clear),
    .active   (cap_active),
    .comp     (comp_mode),
    .cfg_clk  (cfg_clk),
    .cfg_data (cfg_data),
    .count    (byte_count),
    .cap_valid(cap_valid),
    .cap_data (cap_data),
    .complete (complete)
  );

  cfgseq_ctrl #(
    .INIT_CYC(INIT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_done (por_done),
    .cfg_req  (cfg_req),
    .stat_line(stat_line),
    .complete (complete),
    .state    (state),
    .drive_low(stat_drive_low)
  );

endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk #(
  parameter int unsigned TOTAL_BYTES = 16,
  localparam int unsigned CW = $clog2(TOTAL_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_req,
  input logic          stat_ext,
  input logic          stat_line,
  input logic          stat_drive_low,
  input logic          comp_mode,
  input logic          cap_valid,
  input logic [CW-1:0] byte_count,
  input logic [1:0]    stage,
  input logic          por_busy,
  input logic          done,
  input logic          user_oe,
  input logic          complete
);

  // R1
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_busy |-> (stat_drive_low && !stat_line && !user_oe && !done));

  // R3
  stat_wired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_ext |-> !stat_line);

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req |=> (stage == 2'd0));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (byte_count == $past(byte_count) + CW'(1)));

  // R8
  comp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_mode && cap_valid) |=> !cap_valid);

  // R9
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (byte_count == CW'(TOTAL_BYTES) && user_oe));

  // R9
  init_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd2 && $past(stage) == 2'd1) |-> $past(complete));

  // R10
  stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd2) |-> ($past(stage) == 2'd1 || $past(stage) == 2'd2));

endmodule

bind cfg_target_seq cfgseq_chk #(
  .TOTAL_BYTES(TOTAL_BYTES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_req       (cfg_req),
  .stat_ext      (stat_ext),
  .stat_line     (stat_line),
  .stat_drive_low(stat_drive_low),
  .comp_mode     (comp_mode),
  .cap_valid     (cap_valid),
  .byte_count    (byte_count),
  .stage         (stage),
  .por_busy      (por_busy),
  .done          (done),
  .user_oe       (user_oe),
  .complete      (complete)
);

// File: tb/test_cfg_target_seq.sv
`timescale 1ns/1ps
module test_cfg_target_seq;
  localparam int unsigned PL = 40;
  localparam int unsigned PS = 5;
  localparam int unsigned TB = 6;
  localparam int unsigned IC = 4;
  localparam int unsigned CW = $clog2(TB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_short_sel = 1'b0;
  logic cfg_req = 1'b1;
  logic stat_ext = 1'b1;
  logic stat_line, stat_drive_low;
  logic comp_mode = 1'b0;
  logic cfg_clk = 1'b0;
  logic [7:0] cfg_data = '0;
  logic cap_valid;
  logic [7:0] cap_data;
  logic [CW-1:0] byte_count;
  logic [1:0] stage;
  logic por_busy, done, user_oe;

  int nvec = 0;
  int nfail = 0;
  int ngot = 0;
  logic [7:0] got [64];
  logic [7:0] expb [64];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_target_seq #(
    .POR_LONG_CYC(PL), .POR_SHORT_CYC(PS), .TOTAL_BYTES(TB), .INIT_CYC(IC)
  ) i_cfg_target_seq (
    .clk(clk), .rst_n(rst_n), .por_short_sel(por_short_sel), .cfg_req(cfg_req),
    .stat_ext(stat_ext), .stat_line(stat_line), .stat_drive_low(stat_drive_low),
    .comp_mode(comp_mode), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
    .cap_valid(cap_valid), .cap_data(cap_data), .byte_count(byte_count),
    .stage(stage), .por_busy(por_busy), .done(done), .user_oe(user_oe)
  );

  always @(negedge clk) begin
    if (rst_n && cap_valid && ngot < 64) begin
      got[ngot] = cap_data;
      ngot++;
    end
  end

  function automatic bit edge_has_byte(input int idx, input bit comp);
    return comp ? ((idx % 4) == 0) : 1'b1;
  endfunction

  function automatic int edges_needed(input bit comp);
    return comp ? 4 * TB : TB;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_edge(input logic [7:0] d);
    cfg_data = d;
    cfg_clk = 1'b1;
    tick(2);
    cfg_clk = 1'b0;
    tick(2);
  endtask

  task automatic enter_cfg(input bit comp);
    comp_mode = comp;
    cfg_req = 1'b0;
    tick(2);
    chk("R6 stage on request low", stage, 0);
    chk("R3 status low on request low", stat_line, 0);
    chk("R6 count cleared", byte_count, 0);
    cfg_req = 1'b1;
    tick(1);
    chk("R5 config entered", stage, 1);
    chk("R3 status released", stat_line, 1);
    tick(1);
  endtask

  task automatic run_cfg(input bit comp);
    int nexp = 0;
    int nedge = edges_needed(comp);
    int ninit = 0;
    enter_cfg(comp);
    ngot = 0;
    for (int e = 0; e < nedge; e++) begin
      logic [7:0] d = 8'($urandom);
      if (edge_has_byte(e, comp)) begin
        expb[nexp] = d;
        nexp++;
      end
      if (comp && e == nedge - 1) begin
        chk("R8 still config before last processing rise", stage, 1);
        chk("R8 all bytes already captured", byte_count, TB);
      end
      send_edge(d);
    end
    chk(comp ? "R8 captured count" : "R7 captured count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      chk(comp ? "R8 captured byte" : "R7 captured byte", got[i], expb[i]);
    chk("R9 byte_count full", byte_count, TB);
    while (stage == 2'd2 && ninit < 100) begin
      ninit++;
      tick(1);
    end
    chk("R9 init length", ninit, IC - 2);
    chk("R10 user stage reached", stage, 3);
    chk("R9 done", done, 1);
    chk("R9 user_oe", user_oe, 1);
    send_edge(8'hA5);
    chk("R9 no capture after done", ngot, nexp);
    chk("R9 count stays full", byte_count, TB);
  endtask

  task automatic por_run(input bit sel, input int n, input string tag);
    rst_n = 1'b0;
    por_short_sel = sel;
    tick(3);
    chk("R1 stage in reset", stage, 0);
    chk("R1 status low", stat_line, 0);
    chk("R1 user_oe off", user_oe, 0);
    chk("R1 done off", done, 0);
    chk("R1 count zero", byte_count, 0);
    rst_n = 1'b1;
    tick(n);
    chk(tag, por_busy, 1);
    chk("R1 status held low in POR", stat_line, 0);
    tick(1);
    chk(tag, por_busy, 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd7331));
    tick(1);
    por_run(1'b0, PL, "R2 long delay");
    por_run(1'b1, PS, "R2 short delay");

    // R4: external low holds reset
    tick(2);
    cfg_req = 1'b0;
    stat_ext = 1'b0;
    tick(2);
    cfg_req = 1'b1;
    tick(3);
    chk("R4 held in reset by status", stage, 0);
    chk("R4 status line low", stat_line, 0);
    stat_ext = 1'b1;
    tick(1);
    chk("R4 released enters config", stage, 1);

    // directed runs in both modes
    run_cfg(1'b0);
    run_cfg(1'b1);

    // R4: forced low in user mode
    stat_ext = 1'b0;
    tick(1);
    chk("R4 forced reset stage", stage, 0);
    chk("R4 done cleared", done, 0);
    chk("R4 user_oe cleared", user_oe, 0);
    stat_ext = 1'b1;

    // R6: abort mid-config
    enter_cfg(1'b0);
    ngot = 0;
    send_edge(8'h11);
    send_edge(8'h22);
    chk("R7 partial count", byte_count, 2);
    cfg_req = 1'b0;
    tick(1);
    chk("R6 abort stage", stage, 0);
    tick(1);
    chk("R6 abort count", byte_count, 0);

    // random trials
    for (int t = 0; t < 8; t++) run_cfg(1'($urandom));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule